// File: doc/BRIEF.md
# Conditional Render Enable Evaluator

This block decides whether rendering is enabled. On each evaluation request it looks at a two-bit override control and, when the override defers to it, a three-bit mode selector. It then drives a registered execute-enable bit. Two overrides force the answer at once. Under the deferring override, two modes give a fixed answer. Three modes need a comparison record held in memory. The record has four 32-bit fields: a starting sequence, a starting mode word, a present sequence and a present mode word.

For the three comparison modes the block places a fetch request on a ready/valid request port, together with the record address captured at evaluation time. It then waits for the response beat carrying the record. While a fetch is outstanding the busy output is high and the previous enable value stays on the output. The memory behind the port is outside the block. A controller issues `eval_req` only while `busy` is low and uses `exec_en` once `busy` has fallen.

Top module: `cond_render_eval`

## Requirements
- R1: During and directly after reset, `exec_en` is 1, `busy` is 0 and `fetch_req` is 0.
- R2: Override value 1 (always-on) sets `exec_en` to 1 on the edge that accepts the request, with no fetch and no busy cycle, whatever the mode.
- R3: Override value 2 (always-off) sets `exec_en` to 0 on the accepting edge, with no fetch, whatever the mode.
- R4: Override values 0 and 3 defer to the mode. Mode 1 gives enable 1 and mode 0 gives enable 0, both on the accepting edge with no fetch.
- R5: Mode 2 (non-zero test) fetches the record and gives enable 1 only when both the starting sequence and the starting mode word are nonzero.
- R6: Mode 3 (equal test) fetches the record and gives enable 1 when the starting sequence equals the present sequence and the starting mode word equals the present mode word.
- R7: Mode 4 (differ test) fetches the record and gives enable 1 when either pair differs.
- R8: Mode values 5, 6 and 7 are unrecognised. They give enable 1 on the accepting edge with no fetch.
- R9: A fetch is issued only for modes 2, 3 and 4. `fetch_req` rises the cycle after acceptance and stays high, with `fetch_addr` holding the address sampled with the request, until a cycle in which `fetch_ready` is high.
- R10: From acceptance of a comparison mode until the response, `busy` is high and `exec_en` keeps its previous value. The verdict appears on `exec_en` on the edge that samples `rsp_valid` high in the waiting phase, and `busy` falls on that same edge.
- R11: `eval_req` while `busy` is high is ignored. `rsp_valid` outside the waiting phase (idle, or while the request is still being offered) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_req | input | 1 | Start an evaluation (accepted only when not busy) |
| override_sel | input | 2 | 0/3 defer to mode, 1 force on, 2 force off |
| mode_sel | input | 3 | 0 off, 1 on, 2 non-zero test, 3 equal test, 4 differ test, 5-7 on |
| cond_addr | input | 40 | Record address, sampled with the request |
| fetch_req | output | 1 | Record fetch request valid |
| fetch_addr | output | 40 | Record fetch address |
| fetch_ready | input | 1 | Memory accepts the fetch request |
| rsp_valid | input | 1 | Record response beat valid |
| rsp_start_seq | input | 32 | Record starting sequence |
| rsp_start_mode | input | 32 | Record starting mode word |
| rsp_now_seq | input | 32 | Record present sequence |
| rsp_now_mode | input | 32 | Record present mode word |
| exec_en | output | 1 | Registered execute enable |
| busy | output | 1 | High while a fetch is outstanding |

## Verification
Fixed answers (overrides, modes 0, 1 and 5-7) are due one edge after the request is sampled. A comparison verdict is due one edge after the response beat is sampled in the waiting phase. `fetch_req` and `busy` rise one edge after acceptance, and `fetch_req` falls one edge after `fetch_ready` is seen. The bench keeps a behavioural model that is stepped on the same edges from the sampled inputs. It compares every output five nanoseconds after each rising edge, so each result is checked in exactly the cycle it becomes due. Stalled ready, early responses and requests made while busy shift those due cycles, and the model tracks the shift.

// File: rtl/cre_pkg.sv
package cre_pkg;

   typedef enum logic [1:0] {
      OVR_DEFER  = 2'd0,
      OVR_FORCE1 = 2'd1,
      OVR_FORCE0 = 2'd2,
      OVR_DEFER2 = 2'd3
   } ovr_t;

   typedef enum logic [2:0] {
      MD_OFF    = 3'd0,
      MD_ON     = 3'd1,
      MD_NZ     = 3'd2,
      MD_EQ     = 3'd3,
      MD_NE     = 3'd4
   } md_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } st_t;

   function automatic logic needs_record(input logic [2:0] md);
      return (md == MD_NZ) || (md == MD_EQ) || (md == MD_NE);
   endfunction

   function automatic logic defers(input logic [1:0] ov);
      return (ov == OVR_DEFER) || (ov == OVR_DEFER2);
   endfunction

endpackage

// File: rtl/cre_word_cmp.sv
module cre_word_cmp #(
   parameter int WIDTH  = 32,
   parameter int LANE_W = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic             same,
   output logic             a_nonzero
);
   localparam int LANES = WIDTH / LANE_W;

   if (WIDTH % LANE_W != 0) begin : g_bad_lane
      $error("cre_word_cmp: WIDTH must be a multiple of LANE_W");
   end
   if (LANE_W < 1) begin : g_bad_lw
      $error("cre_word_cmp: LANE_W must be positive");
   end

   logic [LANES-1:0] lane_eq;
   logic [LANES-1:0] lane_nz;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_eq[g] = (a[g*LANE_W +: LANE_W] == b[g*LANE_W +: LANE_W]);
      assign lane_nz[g] = |a[g*LANE_W +: LANE_W];
   end

   assign same      = &lane_eq;
   assign a_nonzero = |lane_nz;
endmodule

// File: rtl/cre_verdict.sv
module cre_verdict #(
   parameter int SEQ_W  = 32,
   parameter int MODE_W = 32,
   parameter int LANE_W = 8
) (
   input  logic [2:0]        md,
   input  logic [SEQ_W-1:0]  start_seq,
   input  logic [MODE_W-1:0] start_mode,
   input  logic [SEQ_W-1:0]  now_seq,
   input  logic [MODE_W-1:0] now_mode,
   output logic              verdict
);
   import cre_pkg::*;

   logic seq_same, seq_nz, mode_same, mode_nz;

   cre_word_cmp #(.WIDTH(SEQ_W), .LANE_W(LANE_W)) u_seq (
      .a(start_seq), .b(now_seq), .same(seq_same), .a_nonzero(seq_nz)
   );

   cre_word_cmp #(.WIDTH(MODE_W), .LANE_W(LANE_W)) u_mode (
      .a(start_mode), .b(now_mode), .same(mode_same), .a_nonzero(mode_nz)
   );

   always_comb begin
      unique case (md)
         MD_NZ:   verdict = seq_nz & mode_nz;
         MD_EQ:   verdict = seq_same & mode_same;
         MD_NE:   verdict = ~(seq_same & mode_same);
         default: verdict = 1'b1;
      endcase
   end
endmodule

// File: rtl/cre_fetch_ctl.sv
module cre_fetch_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic start_fetch,
   input  logic fetch_ready,
   input  logic rsp_valid,
   output logic idle,
   output logic offering,
   output logic rsp_take
);
   import cre_pkg::*;

   st_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (start_fetch) st_d = ST_REQ;
         ST_REQ:  if (fetch_ready) st_d = ST_WAIT;
         ST_WAIT: if (rsp_valid)   st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign idle     = (st_q == ST_IDLE);
   assign offering = (st_q == ST_REQ);
   assign rsp_take = (st_q == ST_WAIT) && rsp_valid;
endmodule

// File: rtl/cond_render_eval.sv
module cond_render_eval #(
   parameter int SEQ_W      = 32,
   parameter int MODE_W     = 32,
   parameter int ADDR_W     = 40,
   parameter int LANE_W     = 8,
   parameter bit RESET_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eval_req,
   input  logic [1:0]        override_sel,
   input  logic [2:0]        mode_sel,
   input  logic [ADDR_W-1:0] cond_addr,
   output logic              fetch_req,
   output logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_ready,
   input  logic              rsp_valid,
   input  logic [SEQ_W-1:0]  rsp_start_seq,
   input  logic [MODE_W-1:0] rsp_start_mode,
   input  logic [SEQ_W-1:0]  rsp_now_seq,
   input  logic [MODE_W-1:0] rsp_now_mode,
   output logic              exec_en,
   output logic              busy
);
   import cre_pkg::*;

   if (ADDR_W < 1 || SEQ_W < 1 || MODE_W < 1) begin : g_bad_w
      $error("cond_render_eval: widths must be positive");
   end

   logic idle, offering, rsp_take;
   logic accept, want_fetch, fixed_val, verdict;
   logic [2:0] md_q;
   logic [ADDR_W-1:0] addr_q;
   logic en_q;

   assign accept     = eval_req & idle;
   assign want_fetch = defers(override_sel) & needs_record(mode_sel);

   always_comb begin
      if (override_sel == OVR_FORCE1)      fixed_val = 1'b1;
      else if (override_sel == OVR_FORCE0) fixed_val = 1'b0;
      else if (mode_sel == MD_OFF)         fixed_val = 1'b0;
      else                                 fixed_val = 1'b1;
   end

   cre_fetch_ctl u_ctl (
      .clk(clk), .rst_n(rst_n),
      .start_fetch(accept & want_fetch),
      .fetch_ready(fetch_ready), .rsp_valid(rsp_valid),
      .idle(idle), .offering(offering), .rsp_take(rsp_take)
   );

   cre_verdict #(.SEQ_W(SEQ_W), .MODE_W(MODE_W), .LANE_W(LANE_W)) u_vd (
      .md(md_q),
      .start_seq(rsp_start_seq), .start_mode(rsp_start_mode),
      .now_seq(rsp_now_seq), .now_mode(rsp_now_mode),
      .verdict(verdict)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         md_q   <= MD_OFF;
         addr_q <= '0;
         en_q   <= RESET_EN;
      end else if (accept) begin
         md_q   <= mode_sel;
         addr_q <= cond_addr;
         if (!want_fetch) en_q <= fixed_val;
      end else if (rsp_take) begin
         en_q   <= verdict;
      end
   end

   assign fetch_req  = offering;
   assign fetch_addr = addr_q;
   assign exec_en    = en_q;
   assign busy       = ~idle;
endmodule

// File: rtl/cre_checker.sv
module cre_checker #(
   parameter int ADDR_W = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              eval_req,
   input logic [1:0]        override_sel,
   input logic [2:0]        mode_sel,
   input logic              fetch_req,
   input logic [ADDR_W-1:0] fetch_addr,
   input logic              fetch_ready,
   input logic              rsp_valid,
   input logic              exec_en,
   input logic              busy
);
   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> exec_en && !busy && !fetch_req);

   // R2
   force_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && eval_req && override_sel == 2'd1 |=> exec_en && !busy);

   // R3
   force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && eval_req && override_sel == 2'd2 |=> !exec_en && !busy);

   // R8
   unknown_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && eval_req && (override_sel == 2'd0 || override_sel == 2'd3)
      && mode_sel >= 3'd5 |=> exec_en && !busy);

   // R9
   hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req && !fetch_ready |=> fetch_req && $stable(fetch_addr));

   // R9
   offer_implies_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> busy);

   // R10
   hold_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !(rsp_valid && !fetch_req) |=> $stable(exec_en) && busy);

   // R11
   ignore_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !fetch_req && !rsp_valid |=> busy && !fetch_req);
endmodule

bind cond_render_eval cre_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .eval_req(eval_req),
   .override_sel(override_sel), .mode_sel(mode_sel),
   .fetch_req(fetch_req), .fetch_addr(fetch_addr),
   .fetch_ready(fetch_ready), .rsp_valid(rsp_valid),
   .exec_en(exec_en), .busy(busy)
);

// File: tb/sim_cond_render_eval.sv
`timescale 1ns/1ps
module sim_cond_render_eval;
   localparam int AW = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic eval_req = 1'b0;
   logic [1:0] override_sel = 2'd0;
   logic [2:0] mode_sel = 3'd0;
   logic [AW-1:0] cond_addr = '0;
   logic fetch_req;
   logic [AW-1:0] fetch_addr;
   logic fetch_ready = 1'b0;
   logic rsp_valid = 1'b0;
   logic [31:0] rsp_start_seq = '0, rsp_start_mode = '0, rsp_now_seq = '0, rsp_now_mode = '0;
   logic exec_en, busy;

   always #10 clk = ~clk;

   cond_render_eval u0 (
      .clk(clk), .rst_n(rst_n), .eval_req(eval_req),
      .override_sel(override_sel), .mode_sel(mode_sel), .cond_addr(cond_addr),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
      .rsp_valid(rsp_valid), .rsp_start_seq(rsp_start_seq),
      .rsp_start_mode(rsp_start_mode), .rsp_now_seq(rsp_now_seq),
      .rsp_now_mode(rsp_now_mode), .exec_en(exec_en), .busy(busy)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;
   string tag = "R1";

   // behavioural reference model
   int m_phase = 0;           // 0 idle, 1 offering, 2 waiting
   bit m_en = 1'b1;
   int m_mode = 0;
   logic [AW-1:0] m_addr = '0;

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_phase = 0; m_en = 1'b1; m_addr = '0;
      end else if (m_phase == 0) begin
         if (eval_req) begin
            m_addr = cond_addr;
            if (override_sel == 2'd1) m_en = 1'b1;
            else if (override_sel == 2'd2) m_en = 1'b0;
            else if (mode_sel == 3'd0) m_en = 1'b0;
            else if (mode_sel >= 3'd2 && mode_sel <= 3'd4) begin
               m_phase = 1; m_mode = int'(mode_sel);
            end else m_en = 1'b1;
         end
      end else if (m_phase == 1) begin
         if (fetch_ready) m_phase = 2;
      end else begin
         if (rsp_valid) begin
            if (m_mode == 2)
               m_en = (rsp_start_seq != 0) && (rsp_start_mode != 0);
            else if (m_mode == 3)
               m_en = (rsp_start_seq == rsp_now_seq) && (rsp_start_mode == rsp_now_mode);
            else
               m_en = (rsp_start_seq != rsp_now_seq) || (rsp_start_mode != rsp_now_mode);
            m_phase = 0;
         end
      end
      #5;
      n_chk++;
      if (exec_en !== m_en || busy !== (m_phase != 0) || fetch_req !== (m_phase == 1)
          || (m_phase == 1 && fetch_addr !== m_addr)) begin
         n_fail++;
         $display("FAIL %s: en/busy/req/addr got %b %b %b %h expected %b %b %b %h",
                  tag, exec_en, busy, fetch_req, fetch_addr,
                  m_en, (m_phase != 0), (m_phase == 1), m_addr);
      end
   end

   task automatic run_eval(input string t, input [1:0] ov, input [2:0] md,
                           input [AW-1:0] ad, input int rdy_dly, input int rsp_dly,
                           input [31:0] ss, input [31:0] sm, input [31:0] ns,
                           input [31:0] nm, input bit early_rsp, input bit poke);
      tag = t;
      @(negedge clk);
      override_sel = ov; mode_sel = md; cond_addr = ad; eval_req = 1'b1;
      @(negedge clk);
      eval_req = 1'b0;
      if ((ov == 2'd0 || ov == 2'd3) && md >= 3'd2 && md <= 3'd4) begin
         for (int i = 0; i < rdy_dly; i++) begin
            if (early_rsp) begin
               rsp_valid = 1'b1; rsp_start_seq = ~ss; rsp_now_seq = ss;
            end
            if (poke) begin
               eval_req = 1'b1; override_sel = 2'd2; cond_addr = ~ad;
            end
            @(negedge clk);
         end
         rsp_valid = 1'b0; eval_req = 1'b0; fetch_ready = 1'b1;
         @(negedge clk);
         fetch_ready = 1'b0;
         for (int i = 0; i < rsp_dly; i++) begin
            if (poke) begin eval_req = 1'b1; override_sel = 2'd1; end
            @(negedge clk);
         end
         eval_req = 1'b0;
         rsp_start_seq = ss; rsp_start_mode = sm; rsp_now_seq = ns; rsp_now_mode = nm;
         rsp_valid = 1'b1;
         @(negedge clk);
         rsp_valid = 1'b0;
      end
      @(negedge clk);
   endtask

   initial begin : watchdog
      wait (cycles > 100000);
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected under 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      tag = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 explicit reset-state check
      n_chk++;
      if (exec_en !== 1'b1 || busy !== 1'b0 || fetch_req !== 1'b0) begin
         n_fail++;
         $display("FAIL R1: en/busy/req got %b %b %b expected 1 0 0", exec_en, busy, fetch_req);
      end
      // R11 response beat while idle must be ignored
      tag = "R11";
      rsp_valid = 1'b1; @(negedge clk); rsp_valid = 1'b0;
      run_eval("R3", 2'd2, 3'd1, 40'h0, 0, 0, 0, 0, 0, 0, 0, 0);
      run_eval("R2", 2'd1, 3'd0, 40'h0, 0, 0, 0, 0, 0, 0, 0, 0);
      run_eval("R3", 2'd2, 3'd3, 40'h0, 0, 0, 0, 0, 0, 0, 0, 0);
      run_eval("R2", 2'd1, 3'd4, 40'h0, 0, 0, 0, 0, 0, 0, 0, 0);
      run_eval("R4", 2'd0, 3'd0, 40'h0, 0, 0, 0, 0, 0, 0, 0, 0);
      run_eval("R4", 2'd3, 3'd1, 40'h0, 0, 0, 0, 0, 0, 0, 0, 0);
      run_eval("R4", 2'd3, 3'd0, 40'h0, 0, 0, 0, 0, 0, 0, 0, 0);
      for (int m = 5; m < 8; m++) begin
         run_eval("R4", 2'd0, 3'd0, 40'h0, 0, 0, 0, 0, 0, 0, 0, 0);
         run_eval("R8", 2'd0, 3'(m), 40'h0, 0, 0, 0, 0, 0, 0, 0, 0);
      end
      run_eval("R5", 2'd0, 3'd2, 40'h12_3456_7890, 0, 0, 0, 5, 0, 0, 0, 0);
      run_eval("R5", 2'd0, 3'd2, 40'h00_0000_0040, 1, 1, 3, 0, 0, 0, 0, 0);
      run_eval("R5", 2'd3, 3'd2, 40'hFF_0000_0001, 2, 0, 3, 32'h8000_0000, 0, 0, 0, 0);
      run_eval("R6", 2'd0, 3'd3, 40'hAA_BBBB_CCCC, 0, 2, 7, 9, 7, 9, 0, 0);
      run_eval("R6", 2'd0, 3'd3, 40'h01_0203_0405, 1, 0, 7, 9, 7, 8, 0, 0);
      run_eval("R6", 2'd0, 3'd3, 40'h01_0203_0406, 0, 0, 32'h0100_0000, 9, 0, 9, 0, 0);
      run_eval("R6", 2'd0, 3'd3, 40'h01_0203_0407, 0, 0, 5, 5, 5, 5, 0, 0);
      run_eval("R7", 2'd0, 3'd4, 40'h55_5555_5555, 0, 1, 4, 4, 4, 4, 0, 0);
      run_eval("R7", 2'd0, 3'd4, 40'h55_5555_5556, 0, 0, 4, 4, 5, 4, 0, 0);
      run_eval("R7", 2'd3, 3'd4, 40'h55_5555_5557, 0, 0, 4, 32'h10, 4, 32'h11, 0, 0);
      run_eval("R9", 2'd0, 3'd3, 40'h9A_BCDE_F012, 6, 3, 1, 1, 1, 1, 0, 0);
      run_eval("R10", 2'd0, 3'd4, 40'h33_3333_3333, 3, 5, 2, 2, 2, 2, 0, 0);
      run_eval("R11", 2'd0, 3'd3, 40'h44_4444_4444, 4, 0, 6, 6, 6, 6, 1, 0);
      run_eval("R11", 2'd0, 3'd2, 40'h66_6666_6666, 3, 3, 1, 1, 0, 0, 0, 1);
      run_eval("R11", 2'd0, 3'd5, 40'h0, 0, 0, 0, 0, 0, 0, 0, 0);
      run_eval("R11", 2'd0, 3'd3, 40'h77_7777_7777, 2, 2, 1, 2, 1, 3, 1, 1);
      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule